// File: doc/BRIEF.md
# Selectable Bit-Error-Rate Test Pattern Generator

This block produces one serial test bit per advance strobe for a bit-error-rate tester. A small set of patterns is available: three maximal-length pseudo-random sequences of different periods, a constant low level, a constant high level, and a programmable word of 17 to 20 bits that repeats. The selected pattern drives a single output bit. Downstream logic sends that bit into whatever channel is under test.

The advance strobe may be gapped, so the generator can follow a timeslot or a gapped line clock. It moves only on cycles where the strobe is high. A synchronous load pulse captures the pattern select, the word, its length code and a seed, and restarts every sequence from that point. The configuration inputs are ignored at all other times, so a new pattern never begins partway through the one that is running.

Top module: `pattgen_top`

## Requirements
- R1: Mode code 3'b010 gives a pseudo-random sequence of period 63 from a 6-bit register. The register has feedback polynomial x^6+x^5+1, shifts toward its MSB with the new bit entering at bit 0, and puts out its MSB.
- R2: Mode code 3'b011 gives a period-511 sequence from a 9-bit register of the same form, with polynomial x^9+x^5+1.
- R3: Mode code 3'b100 gives a period-8,388,607 sequence from a 23-bit register of the same form, with polynomial x^23+x^18+1.
- R4: Mode code 3'b000 holds the output at 0 and mode code 3'b001 holds it at 1. Codes 3'b110 and 3'b111 behave as 3'b000.
- R5: In mode code 3'b101, a 4-bit length code sets the loop length L: 0000 gives 17, 0001 gives 18, 0010 gives 19, 0011 gives 20, and any larger code gives 20.
- R6: The repeating word takes bits word_i[L-1:0]. Bit L-1 goes out first, then the bits in descending order down to bit 0, and then the loop wraps back to bit L-1.
- R7: A cycle with enable_i low and load_i low leaves the output and all sequence state unchanged.
- R8: A load reseeds each pseudo-random register with the low bits of seed_i that match its width. The output is the first bit of the new sequence in the cycle after the load edge. A seed field that is all zeros is replaced with all ones.
- R9: mode_i, len_code_i and word_i are captured only on a load edge. Changing them at any other time has no effect on the output.
- R10: After reset the mode is all-zeros, so bit_o is 0 until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Captures the configuration and reseeds the generators |
| enable_i | input | 1 | Advances the pattern by one bit when high |
| mode_i | input | 3 | Pattern select, captured at load |
| len_code_i | input | 4 | Length code for the repeating word, captured at load |
| word_i | input | 20 | Repeating word, captured at load |
| seed_i | input | 23 | Seed for the pseudo-random registers |
| bit_o | output | 1 | Serial test bit |

## Verification
The output comes from registered state through a combinational select. The first bit of a new pattern is therefore valid in the cycle right after the load edge, and each later bit is valid in the cycle after each edge where enable_i is high. The bench drives its inputs and samples bit_o one time unit after each rising edge. It moves its reference model forward only when the preceding edge saw enable high, so every comparison lines up with the edge that produced the bit. Every pseudo-random mode is compared bit for bit against the polynomial. The word mode is swept over every length code and over several words, and the check covers more than one wrap of the loop.

// File: rtl/pattgen_pkg.sv
package pattgen_pkg;

    localparam int WORD_MIN   = 17;
    localparam int WORD_MAX   = 20;
    localparam int LEN_CODE_W = 4;
    localparam int SEED_W     = 23;
    localparam int CNT_W      = $clog2(WORD_MAX + 1);
    localparam int NUM_PN     = 3;

    // per-generator register width and second feedback tap (1-based)
    localparam int PN_WIDTH [NUM_PN] = '{6, 9, 23};
    localparam int PN_TAP   [NUM_PN] = '{5, 5, 18};

    typedef enum logic [2:0] {
        PG_ZEROS = 3'd0,
        PG_ONES  = 3'd1,
        PG_PN6   = 3'd2,
        PG_PN9   = 3'd3,
        PG_PN23  = 3'd4,
        PG_WORD  = 3'd5
    } pg_mode_e;

    function automatic logic [CNT_W-1:0] code_to_len(input logic [LEN_CODE_W-1:0] code);
        if (code > LEN_CODE_W'(3))
            return CNT_W'(WORD_MAX);
        return CNT_W'(WORD_MIN) + CNT_W'(code);
    endfunction

endpackage

// File: rtl/pattgen_lfsr.sv
module pattgen_lfsr #(
    parameter int WIDTH = 6,
    parameter int TAP   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             enable_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic             bit_o
);

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] seed_fix;
    logic             feedback;

    assign seed_fix = (seed_i == '0) ? '1 : seed_i;
    assign feedback = state_q[WIDTH-1] ^ state_q[TAP-1];
    assign bit_o    = state_q[WIDTH-1];

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '1;
        else if (load_i)
            state_q <= seed_fix;
        else if (enable_i)
            state_q <= {state_q[WIDTH-2:0], feedback};
    end

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);  // R8
    AST_SEED_FIX: assert property (@(posedge clk) disable iff (rst)
        (load_i && seed_i == '0) |=> state_q == '1);  // R8
    AST_PN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !enable_i) |=> $stable(state_q));  // R7

endmodule

// File: rtl/pattgen_word.sv
module pattgen_word
    import pattgen_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_i,
    input  logic                  enable_i,
    input  logic [WORD_MAX-1:0]   word_i,
    input  logic [CNT_W-1:0]      len_i,
    output logic                  bit_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [WORD_MAX-1:0] word_q;
    logic [CNT_W-1:0]    len_q;
    logic [CNT_W-1:0]    idx_q;

    assign bit_o = word_q[idx_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            len_q  <= CNT_W'(WORD_MAX);
            idx_q  <= CNT_W'(WORD_MAX - 1);
        end else if (load_i) begin
            word_q <= word_i;
            len_q  <= len_i;
            idx_q  <= len_i - ONE;
        end else if (enable_i) begin
            idx_q  <= (idx_q == '0) ? len_q - ONE : idx_q - ONE;
        end
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        idx_q < len_q);  // R5
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        len_q >= CNT_W'(WORD_MIN) && len_q <= CNT_W'(WORD_MAX));  // R5
    AST_WORD_WRAP: assert property (@(posedge clk) disable iff (rst)
        (enable_i && !load_i && idx_q == '0) |=> idx_q == len_q - ONE);  // R6
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !enable_i) |=> $stable(idx_q) && $stable(word_q));  // R7

endmodule

// File: rtl/pattgen_top.sv
module pattgen_top
    import pattgen_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_i,
    input  logic                  enable_i,
    input  logic [2:0]            mode_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic [WORD_MAX-1:0]   word_i,
    input  logic [SEED_W-1:0]     seed_i,
    output logic                  bit_o
);

    pg_mode_e          mode_q;
    logic [NUM_PN-1:0] pn_bit;
    logic              word_bit;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= PG_ZEROS;
        else if (load_i)
            mode_q <= pg_mode_e'(mode_i);
    end

    for (genvar g = 0; g < NUM_PN; g++) begin : g_pn
        pattgen_lfsr #(
            .WIDTH (PN_WIDTH[g]),
            .TAP   (PN_TAP[g])
        ) u_lfsr (
            .clk      (clk),
            .rst      (rst),
            .load_i   (load_i),
            .enable_i (enable_i),
            .seed_i   (seed_i[PN_WIDTH[g]-1:0]),
            .bit_o    (pn_bit[g])
        );
    end

    pattgen_word u_word (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load_i),
        .enable_i (enable_i),
        .word_i   (word_i),
        .len_i    (code_to_len(len_code_i)),
        .bit_o    (word_bit)
    );

    always_comb begin
        case (mode_q)
            PG_ONES:  bit_o = 1'b1;
            PG_PN6:   bit_o = pn_bit[0];
            PG_PN9:   bit_o = pn_bit[1];
            PG_PN23:  bit_o = pn_bit[2];
            PG_WORD:  bit_o = word_bit;
            default:  bit_o = 1'b0;
        endcase
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(mode_q));  // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !enable_i) |=> $stable(bit_o));  // R7

endmodule

// File: tb/tb_pattgen_top.sv
module tb_pattgen_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic        enable_i = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic [3:0]  len_code_i = 4'd0;
    logic [19:0] word_i = '0;
    logic [22:0] seed_i = '0;
    logic        bit_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pattgen_top dut (
        .clk(clk), .rst(rst), .load_i(load_i), .enable_i(enable_i),
        .mode_i(mode_i), .len_code_i(len_code_i), .word_i(word_i),
        .seed_i(seed_i), .bit_o(bit_o)
    );

    task automatic check(input string req, input logic actual, input logic expected, input int idx);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s bit %0d: actual %b expected %b", req, idx, actual, expected);
        end
    endtask

    task automatic check_int(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_load(input logic [2:0] m, input logic [3:0] c,
                           input logic [19:0] w, input logic [22:0] s);
        mode_i = m; len_code_i = c; word_i = w; seed_i = s;
        load_i = 1'b1; enable_i = 1'b1;
        tick();
        load_i = 1'b0;
    endtask

    // reference step from the polynomial x^w + x^t + 1
    function automatic logic [22:0] pn_next(input logic [22:0] s, input int w, input int t);
        logic [22:0] n;
        n = s << 1;
        n[0] = s[w-1] ^ s[t-1];
        for (int k = w; k < 23; k++) n[k] = 1'b0;
        return n;
    endfunction

    task automatic run_pn(input string req, input logic [2:0] m, input int w, input int t,
                          input logic [22:0] seed, input int nbits, input bit count_ones);
        logic [22:0] s;
        int ones;
        int per;
        s = '0;
        for (int k = 0; k < w; k++) s[k] = seed[k];
        if (s == '0) for (int k = 0; k < w; k++) s[k] = 1'b1;
        do_load(m, 4'd0, 20'h0, seed);
        per = (1 << w) - 1;
        ones = 0;
        for (int i = 0; i < nbits; i++) begin
            check(req, bit_o, s[w-1], i);
            if (i < per) ones += int'(bit_o);
            s = pn_next(s, w, t);
            tick();
        end
        if (count_ones) check_int({req, " ones per period"}, ones, 1 << (w-1));
    endtask

    task automatic run_word(input logic [3:0] c, input logic [19:0] w);
        int len;
        len = (c > 4'd3) ? 20 : 17 + int'(c);
        do_load(3'd5, c, w, 23'h1);
        for (int i = 0; i < 3*len + 2; i++) begin
            check("R5/R6 word", bit_o, w[len-1 - (i % len)], i);
            tick();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R10: reset state
        check("R10 reset", bit_o, 1'b0, 0);
        enable_i = 1'b1;
        for (int i = 0; i < 8; i++) begin tick(); check("R10 after reset", bit_o, 1'b0, i); end

        // R4: fixed patterns
        do_load(3'd1, 4'd0, 20'h0, 23'h0);
        for (int i = 0; i < 40; i++) begin check("R4 ones", bit_o, 1'b1, i); tick(); end
        do_load(3'd0, 4'd0, 20'hFFFFF, 23'h5);
        for (int i = 0; i < 40; i++) begin check("R4 zeros", bit_o, 1'b0, i); tick(); end
        do_load(3'd7, 4'd0, 20'hFFFFF, 23'h5);
        for (int i = 0; i < 20; i++) begin check("R4 code 7", bit_o, 1'b0, i); tick(); end

        // R1, R2, R3 and R8 seeding
        run_pn("R1 pn6", 3'd2, 6, 5, 23'h15, 130, 1'b1);
        run_pn("R1 pn6 zero seed R8", 3'd2, 6, 5, 23'h0, 70, 1'b1);
        run_pn("R2 pn9", 3'd3, 9, 5, 23'h1A5, 1030, 1'b1);
        run_pn("R3 pn23", 3'd4, 23, 18, 23'h3C0F1, 3000, 1'b0);
        run_pn("R3 pn23 zero seed R8", 3'd4, 23, 18, 23'h0, 200, 1'b0);

        // R5, R6: every length code, several words
        for (int c = 0; c < 16; c++) begin
            run_word(4'(c), 20'hB5A3C ^ 20'(c * 20'h1357));
        end
        run_word(4'd0, 20'h00001);
        run_word(4'd3, 20'h80000);
        run_word(4'd2, 20'h40001);

        // R7: gapped enable on pn9
        begin
            logic [22:0] s;
            logic en;
            s = 23'h0AB;
            do_load(3'd3, 4'd0, 20'h0, 23'h0AB);
            for (int i = 0; i < 300; i++) begin
                check("R7 gapped", bit_o, s[8], i);
                en = (i % 3) != 0;
                enable_i = en;
                tick();
                if (en) s = pn_next(s, 9, 5);
            end
            enable_i = 1'b1;
        end

        // R9: config changes without load are ignored
        begin
            logic [22:0] s;
            s = 23'h2D;
            do_load(3'd2, 4'd0, 20'h0, 23'h2D);
            mode_i = 3'd1; len_code_i = 4'd3; word_i = 20'hFFFFF; seed_i = 23'h0;
            for (int i = 0; i < 70; i++) begin
                check("R9 ignore", bit_o, s[5], i);
                s = pn_next(s, 6, 5);
                tick();
            end
            load_i = 1'b1; tick(); load_i = 1'b0;
            for (int i = 0; i < 10; i++) begin check("R9 after load", bit_o, 1'b1, i); tick(); end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule